// File: doc/BRIEF.md
# Display Module Parallel Host Port

This block is the module-side end of an asynchronous 8-bit bidirectional host bus on a character/graphics display. The host talks to it only through level strobes: a write strobe, an active-low read strobe, an active-low unit select, an active-low host reset, an active-low blank input and a brightness input. The block passes every strobe through a two-flop synchronizer before using it.

A byte is taken from the bus on each synchronized low-to-high transition of the write strobe. This happens only while the unit is selected and no read is in progress. Captured bytes enter a receive FIFO, and a downstream consumer drains it with a valid/ready handshake. A producer pushes reply bytes into a response FIFO with the same handshake. While the host reads, the block drives the oldest reply byte onto the bus, and a data-present flag tells the host when a reply is waiting.

A busy flag covers three conditions: the fixed processing time after each captured byte, a full receive FIFO, and the timed reset cycle that follows power-up or a host reset. The blank and brightness inputs are synchronized and passed on to the display core as plain controls.

Top module: `panel_host_port`

## Requirements
- R1: A byte is pushed into the receive FIFO once for each low-to-high transition of `hst_wr` that happens while `hst_sel_n` is 0 and `hst_rd_n` is 1. Holding `hst_wr` low or high for any length of time adds no further byte.
- R2: While `hst_sel_n` is 1, a write transition pushes nothing, and a low `hst_rd_n` leaves `hst_data_oe` at 0 and removes no reply byte.
- R3: While `hst_sel_n` is 0, `hst_rd_n` is 0 and `hst_wr` is 1, `hst_data_oe` is 1 and `hst_data_out` carries the oldest queued reply byte.
- R4: `hst_avail` is 1 exactly when the response FIFO holds a byte. A read that completes (`hst_rd_n` returns to 1 after driving) removes one byte, so `hst_avail` stays 1 if more bytes are queued and goes to 0 otherwise.
- R5: `hst_busy` is 1 for PROC_CYCLES clock cycles after each captured byte and then goes back to 0, provided no other busy condition holds.
- R6: `hst_busy` is 1 while the receive FIFO holds RX_DEPTH bytes. A write in that state is discarded, `rx_drop` pulses high for one cycle, and the buffered bytes are unchanged.
- R7: Received bytes leave on `rx_data` in arrival order. While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` and `rx_data` hold.
- R8: `hst_reset_n` at 0 (or `rst_n` at 0) empties both FIFOs and holds `hst_busy` at 1. After release, `hst_busy` stays 1 for RST_CYCLES further cycles and writes are ignored during that time; afterwards `hst_busy` returns to 0.
- R9: `disp_blank` is 1 while `hst_blank_n` is 0. `disp_full_bright` follows `hst_bright` (1 = full, 0 = half brightness). Both follow their inputs after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hst_data_in | input | DW | Host bus value seen by the module |
| hst_data_out | output | DW | Reply byte driven toward the host |
| hst_data_oe | output | 1 | Bus drive enable (1 = module drives) |
| hst_wr | input | 1 | Write strobe, byte taken on its rising edge |
| hst_rd_n | input | 1 | Read strobe, active low |
| hst_sel_n | input | 1 | Unit select, active low |
| hst_reset_n | input | 1 | Host reset, active low |
| hst_blank_n | input | 1 | Blank request, active low |
| hst_bright | input | 1 | 1 = full brightness, 0 = half |
| hst_busy | output | 1 | Host must not send while 1 |
| hst_avail | output | 1 | Reply byte ready to read |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | DW | Oldest received byte |
| rx_drop | output | 1 | One-cycle pulse on a write lost to a full FIFO |
| tx_valid | input | 1 | Producer offers a reply byte |
| tx_ready | output | 1 | Response FIFO has room |
| tx_data | input | DW | Reply byte from producer |
| disp_blank | output | 1 | Blank the display |
| disp_full_bright | output | 1 | Full brightness select |

## Verification
The hardest state to reach is a completed read that leaves a second reply queued. Reaching it needs the producer to have pushed two bytes before the host's first read strobe ends. The bench fills the response FIFO through the producer handshake, then runs two full read strobes and checks the data-present flag in the gap between them. The drop path needs the receive FIFO filled while the consumer holds ready low. A write is then sent after the processing window has expired, so that only the full condition keeps busy high.

// File: rtl/hostif_pkg.sv
// Shared types for the display host port.
// Assumes all host strobes are sampled together by a single synchronizer.
package hostif_pkg;

    typedef struct packed {
        logic wr;
        logic rd_n;
        logic sel_n;
        logic blank_n;
        logic bright;
        logic reset_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{wr: 1'b1, rd_n: 1'b1, sel_n: 1'b1,
                                         blank_n: 1'b1, bright: 1'b1, reset_n: 1'b1};

endpackage

// File: rtl/hif_sync.sv
// Two-flop synchronizer for a bundle of asynchronous host signals.
// Assumes each bit is independently asynchronous; multi-bit values are only
// used when the host holds them stable around the qualifying strobe.
module hif_sync #(
    parameter int          W         = 1,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage resample of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RESET_VAL;
            q      <= RESET_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hif_fifo.sv
// Count-based synchronous FIFO with combinational head output.
// Assumes push while full and pop while empty are ignored here.
module hif_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hif_timer.sv
// Down-counter that keeps a flag high for a fixed number of cycles.
// Used both for the reset cycle and the per-byte processing window.
// Assumes load wins over counting.
module hif_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int CW = (CYCLES > 0) ? $clog2(CYCLES + 1) : 1;

    logic [CW-1:0] cnt;

    assign active = (cnt != '0);

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= CW'(CYCLES);
        else if (active) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/panel_host_port.sv
// Module-side port of an asynchronous 8-bit host bus for a display.
// Synchronizes all host strobes, captures bytes on write rising edges,
// serves reply bytes on reads, and drives busy / data-present handshakes.
// Assumes the host holds data stable from WR low until after WR high has
// been sampled, and keeps strobes stable for at least three clock cycles.
module panel_host_port
    import hostif_pkg::*;
#(
    parameter int DW          = 8,
    parameter int RX_DEPTH    = 16,
    parameter int TX_DEPTH    = 4,
    parameter int PROC_CYCLES = 4,
    parameter int RST_CYCLES  = 12_500_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hst_data_in,
    output logic [DW-1:0] hst_data_out,
    output logic          hst_data_oe,
    input  logic          hst_wr,
    input  logic          hst_rd_n,
    input  logic          hst_sel_n,
    input  logic          hst_reset_n,
    input  logic          hst_blank_n,
    input  logic          hst_bright,
    output logic          hst_busy,
    output logic          hst_avail,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_drop,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic [DW-1:0] tx_data,
    output logic          disp_blank,
    output logic          disp_full_bright
);
    localparam int SW = $bits(strobe_t);

    strobe_t       stb_raw, stb_s;
    logic [DW-1:0] data_s;
    logic          core_rst_n;
    logic          wr_q, rd_active;
    logic          wr_rise, rd_done, read_cond;
    logic          rx_push, rx_full, rx_empty;
    logic          tx_full, tx_empty;
    logic [DW-1:0] tx_head;
    logic          rst_active, proc_active;

    assign stb_raw = '{wr: hst_wr, rd_n: hst_rd_n, sel_n: hst_sel_n,
                       blank_n: hst_blank_n, bright: hst_bright, reset_n: hst_reset_n};

    hif_sync #(
        .W         (SW + DW),
        .RESET_VAL ({STROBE_IDLE, {DW{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({stb_raw, hst_data_in}),
        .q     ({stb_s, data_s})
    );

    assign core_rst_n = rst_n && stb_s.reset_n;

    // Edge history for write and read strobes.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            wr_q      <= 1'b1;
            rd_active <= 1'b0;
        end else begin
            wr_q      <= stb_s.wr;
            rd_active <= read_cond;
        end
    end

    assign read_cond = !stb_s.sel_n && !stb_s.rd_n && stb_s.wr;
    assign wr_rise   = stb_s.wr && !wr_q && !stb_s.sel_n && stb_s.rd_n && !rst_active;
    assign rd_done   = rd_active && stb_s.rd_n;
    assign rx_push   = wr_rise && !rx_full;

    // Receive side: host writes in, consumer drains.
    hif_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (core_rst_n),
        .push  (rx_push),
        .din   (data_s),
        .pop   (rx_ready),
        .dout  (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // Response side: producer fills, host reads out.
    hif_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (core_rst_n),
        .push  (tx_valid),
        .din   (tx_data),
        .pop   (rd_done),
        .dout  (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    // Reset cycle: reloaded throughout any core reset.
    hif_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
        .clk    (clk),
        .rst_n  (1'b1),
        .load   (!core_rst_n),
        .active (rst_active)
    );

    // Processing window after each captured byte.
    hif_timer #(.CYCLES(PROC_CYCLES)) u_proc_timer (
        .clk    (clk),
        .rst_n  (core_rst_n),
        .load   (rx_push),
        .active (proc_active)
    );

    // Lost-write indication.
    always_ff @(posedge clk) begin
        if (!core_rst_n) rx_drop <= 1'b0;
        else             rx_drop <= wr_rise && rx_full;
    end

    assign rx_valid         = !rx_empty;
    assign tx_ready         = !tx_full;
    assign hst_avail        = !tx_empty;
    assign hst_data_oe      = read_cond;
    assign hst_data_out     = tx_empty ? '0 : tx_head;
    assign hst_busy         = !core_rst_n || rst_active || proc_active || rx_full;
    assign disp_blank       = !stb_s.blank_n;
    assign disp_full_bright = stb_s.bright;

endmodule

// File: rtl/panel_host_port_chk.sv
// Property checker for panel_host_port, attached by bind below.
// Assumes it sees the top-level ports plus the internal core reset and
// read-completion strobe.
module panel_host_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_rst_n,
    input logic          hst_sel_n,
    input logic          hst_data_oe,
    input logic          hst_busy,
    input logic          hst_avail,
    input logic          rx_push,
    input logic          rx_drop,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [DW-1:0] rx_data,
    input logic          rd_done
);
    // R2
    deselect_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_data_oe |-> !$past(hst_sel_n, 2));

    // R5
    capture_busy_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
        rx_push |=> hst_busy);

    // R6
    drop_while_busy_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
        rx_drop |-> hst_busy);

    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R4
    avail_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hst_avail) |-> ($past(rd_done) || !$past(core_rst_n)));

    // R8
    reset_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |=> hst_busy);
endmodule

bind panel_host_port panel_host_port_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_rst_n  (core_rst_n),
    .hst_sel_n   (hst_sel_n),
    .hst_data_oe (hst_data_oe),
    .hst_busy    (hst_busy),
    .hst_avail   (hst_avail),
    .rx_push     (rx_push),
    .rx_drop     (rx_drop),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .rd_done     (rd_done)
);

// File: tb/tb_panel_host_port.sv
// Directed bench for panel_host_port: one task per scenario.
module tb_panel_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int RXD        = 4;
    localparam int TXD        = 4;
    localparam int PROC       = 4;
    localparam int RSTC       = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] hst_data_in = '0;
    logic [DW-1:0] hst_data_out;
    logic          hst_data_oe;
    logic          hst_wr = 1'b1, hst_rd_n = 1'b1, hst_sel_n = 1'b0;
    logic          hst_reset_n = 1'b1, hst_blank_n = 1'b1, hst_bright = 1'b1;
    logic          hst_busy, hst_avail;
    logic          rx_valid, rx_ready = 1'b0, rx_drop;
    logic [DW-1:0] rx_data;
    logic          tx_valid = 1'b0, tx_ready;
    logic [DW-1:0] tx_data = '0;
    logic          disp_blank, disp_full_bright;

    int checks = 0;
    int fails  = 0;
    int drops  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    panel_host_port #(
        .DW(DW), .RX_DEPTH(RXD), .TX_DEPTH(TXD),
        .PROC_CYCLES(PROC), .RST_CYCLES(RSTC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .hst_data_in(hst_data_in),
        .hst_data_out(hst_data_out), .hst_data_oe(hst_data_oe),
        .hst_wr(hst_wr), .hst_rd_n(hst_rd_n), .hst_sel_n(hst_sel_n),
        .hst_reset_n(hst_reset_n), .hst_blank_n(hst_blank_n),
        .hst_bright(hst_bright), .hst_busy(hst_busy), .hst_avail(hst_avail),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_drop(rx_drop), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .disp_blank(disp_blank),
        .disp_full_bright(disp_full_bright)
    );

    // Count lost-write pulses, sampled between edges.
    always @(negedge clk) if (rx_drop) drops++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [DW-1:0] b);
        hst_data_in = b;
        hst_wr = 1'b0;
        tick(4);
        hst_wr = 1'b1;
        tick(3);
    endtask

    task automatic host_read(output logic [DW-1:0] got, output logic oe);
        hst_rd_n = 1'b0;
        tick(4);
        oe  = hst_data_oe;
        got = hst_data_out;
        hst_rd_n = 1'b1;
        tick(4);
    endtask

    task automatic rx_take(input logic [DW-1:0] exp, input string tag);
        chk(rx_valid == 1'b1, tag, 32'(rx_valid), 32'd1);
        chk(rx_data == exp, tag, 32'(rx_data), 32'(exp));
        rx_ready = 1'b1;
        tick(1);
        rx_ready = 1'b0;
    endtask

    task automatic tx_put(input logic [DW-1:0] b);
        chk(tx_ready == 1'b1, "R4 tx_ready", 32'(tx_ready), 32'd1);
        tx_valid = 1'b1;
        tx_data  = b;
        tick(1);
        tx_valid = 1'b0;
    endtask

    task automatic t_power_up;
        tick(5);
        chk(hst_busy == 1'b1, "R8 busy in reset", 32'(hst_busy), 32'd1);
        rst_n = 1'b1;
        tick(2);
        chk(hst_busy == 1'b1, "R8 busy in reset cycle", 32'(hst_busy), 32'd1);
        chk(rx_valid == 1'b0, "R8 rx empty", 32'(rx_valid), 32'd0);
        chk(hst_avail == 1'b0, "R4 avail low", 32'(hst_avail), 32'd0);
        chk(hst_data_oe == 1'b0, "R2 no drive", 32'(hst_data_oe), 32'd0);
        tick(RSTC + 4);
        chk(hst_busy == 1'b0, "R8 busy after cycle", 32'(hst_busy), 32'd0);
    endtask

    task automatic t_busy_window;
        host_write(8'hA5);
        chk(hst_busy == 1'b1, "R5 busy after write", 32'(hst_busy), 32'd1);
        tick(5);
        chk(hst_busy == 1'b0, "R5 busy released", 32'(hst_busy), 32'd0);
        rx_take(8'hA5, "R1 captured byte");
        chk(rx_valid == 1'b0, "R1 single byte", 32'(rx_valid), 32'd0);
    endtask

    task automatic t_one_per_edge;
        hst_data_in = 8'h5A;
        hst_wr = 1'b0;
        tick(20);
        hst_wr = 1'b1;
        tick(20);
        rx_take(8'h5A, "R1 long strobe byte");
        chk(rx_valid == 1'b0, "R1 long strobe one byte", 32'(rx_valid), 32'd0);
    endtask

    task automatic t_order_hold;
        host_write(8'h01);
        host_write(8'h02);
        host_write(8'h03);
        tick(10);
        chk(rx_data == 8'h01, "R7 hold head", 32'(rx_data), 32'h01);
        rx_take(8'h01, "R7 order 1");
        rx_take(8'h02, "R7 order 2");
        rx_take(8'h03, "R7 order 3");
        chk(rx_valid == 1'b0, "R7 drained", 32'(rx_valid), 32'd0);
    endtask

    task automatic t_full_drop;
        int d0;
        d0 = drops;
        for (int i = 0; i < RXD; i++) host_write(8'h40 + 8'(i));
        tick(PROC + 3);
        chk(hst_busy == 1'b1, "R6 busy when full", 32'(hst_busy), 32'd1);
        chk(drops == d0, "R6 no drop yet", 32'(drops), 32'(d0));
        host_write(8'hEE);
        tick(2);
        chk(drops == d0 + 1, "R6 drop pulse", 32'(drops), 32'(d0 + 1));
        for (int i = 0; i < RXD; i++) rx_take(8'h40 + 8'(i), "R6 kept bytes");
        chk(rx_valid == 1'b0, "R6 dropped byte absent", 32'(rx_valid), 32'd0);
        tick(1);
        chk(hst_busy == 1'b0, "R6 busy clears", 32'(hst_busy), 32'd0);
    endtask

    task automatic t_read_two;
        logic [DW-1:0] got;
        logic oe;
        tx_put(8'hC1);
        tx_put(8'hC2);
        tick(1);
        chk(hst_avail == 1'b1, "R4 avail set", 32'(hst_avail), 32'd1);
        host_read(got, oe);
        chk(oe == 1'b1, "R3 drive on read", 32'(oe), 32'd1);
        chk(got == 8'hC1, "R3 first reply", 32'(got), 32'hC1);
        chk(hst_data_oe == 1'b0, "R3 release bus", 32'(hst_data_oe), 32'd0);
        chk(hst_avail == 1'b1, "R4 avail with second queued", 32'(hst_avail), 32'd1);
        host_read(got, oe);
        chk(got == 8'hC2, "R3 second reply", 32'(got), 32'hC2);
        chk(hst_avail == 1'b0, "R4 avail clears", 32'(hst_avail), 32'd0);
    endtask

    task automatic t_deselect;
        logic [DW-1:0] got;
        logic oe;
        hst_sel_n = 1'b1;
        host_write(8'h77);
        tick(6);
        chk(rx_valid == 1'b0, "R2 write ignored", 32'(rx_valid), 32'd0);
        chk(hst_busy == 1'b0, "R2 no busy", 32'(hst_busy), 32'd0);
        hst_sel_n = 1'b0;
        tx_put(8'h9D);
        hst_sel_n = 1'b1;
        host_read(got, oe);
        chk(oe == 1'b0, "R2 bus undriven", 32'(oe), 32'd0);
        chk(hst_avail == 1'b1, "R2 reply kept", 32'(hst_avail), 32'd1);
        hst_sel_n = 1'b0;
        tick(3);
        host_read(got, oe);
        chk(got == 8'h9D, "R2 reply intact", 32'(got), 32'h9D);
    endtask

    task automatic t_display_ctl;
        hst_blank_n = 1'b0;
        hst_bright  = 1'b0;
        tick(3);
        chk(disp_blank == 1'b1, "R9 blank on", 32'(disp_blank), 32'd1);
        chk(disp_full_bright == 1'b0, "R9 half bright", 32'(disp_full_bright), 32'd0);
        hst_blank_n = 1'b1;
        hst_bright  = 1'b1;
        tick(3);
        chk(disp_blank == 1'b0, "R9 blank off", 32'(disp_blank), 32'd0);
        chk(disp_full_bright == 1'b1, "R9 full bright", 32'(disp_full_bright), 32'd1);
    endtask

    task automatic t_host_reset;
        host_write(8'h33);
        tx_put(8'h44);
        tick(2);
        hst_reset_n = 1'b0;
        tick(5);
        chk(rx_valid == 1'b0, "R8 rx cleared", 32'(rx_valid), 32'd0);
        chk(hst_avail == 1'b0, "R8 tx cleared", 32'(hst_avail), 32'd0);
        chk(hst_busy == 1'b1, "R8 busy in host reset", 32'(hst_busy), 32'd1);
        hst_reset_n = 1'b1;
        tick(4);
        host_write(8'h55);
        tick(2);
        chk(hst_busy == 1'b1, "R8 busy in reset cycle", 32'(hst_busy), 32'd1);
        chk(rx_valid == 1'b0, "R8 write ignored", 32'(rx_valid), 32'd0);
        tick(RSTC);
        chk(hst_busy == 1'b0, "R8 busy ends", 32'(hst_busy), 32'd0);
        chk(rx_valid == 1'b0, "R8 still empty", 32'(rx_valid), 32'd0);
    endtask

    initial begin
        t_power_up();
        t_busy_window();
        t_one_per_edge();
        t_order_hold();
        t_full_drop();
        t_read_two();
        t_deselect();
        t_display_ctl();
        t_host_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule